// File: doc/BRIEF.md
# DMA Transfer Mode Sequencer

This block sits behind a channel arbiter and decides how much of a programmed transaction a single granted request moves. A transaction consists of a number of blocks, and every block holds the same number of bytes. The sequencer breaks each block into beats of the programmed item width. The last beat of a block may be shorter. Beats go out as commands on a valid/ready port to a datapath that does the actual read and write. The request mode sets where the sequencer stops: after one item, at the end of the current block, or at the end of the whole transaction.

A three-level completion hierarchy drives three sticky status flags: item done, block done and transaction done. Each flag has its own interrupt mask bit. When the transaction ends, the channel enable bit clears by itself. The block size and block count are captured when a transaction opens, so software can program the next transaction while the current one is still running. The command port follows the usual rules for back-pressure. While `cmd_valid` is high and `cmd_ready` is low, the command fields are held and no counter moves. A beat completes only on a cycle where both signals are high.

Top module: `dma_mode_seq`

## Requirements
- R1: `en_set` sets `ch_en`. A `req` pulse is accepted only when `ch_en` is 1 and no request is running. Any other `req` is ignored and produces no command.
- R2: Each beat carries min(item width, bytes left in the block) bytes. The `cfg_width` encoding is 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R3: With `cfg_mode` 0 (or the reserved code 3), an accepted request issues exactly one beat.
- R4: With `cfg_mode` 1, an accepted request issues beats until the current block ends.
- R5: With `cfg_mode` 2, an accepted request issues beats until every remaining block of the transaction is done.
- R6: Flag bit 0 (item) sets one cycle after every completed beat. Bit 1 (block) sets in that same cycle when the beat ended a block. Bit 2 (transaction) sets in that same cycle when the beat ended the last block.
- R7: `ch_en` drops in the same cycle that the transaction flag is set.
- R8: Flags hold until written with a one on `flag_clr`. If a bit is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some flag bit and its `irq_mask` bit are both 1.
- R10: Block size and block count are sampled when a request opens a new transaction. Changes made later take effect only in the next transaction. Mode and width are sampled at every accepted request.
- R11: A block size or block count programmed as zero behaves as one.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_bytes` and the last markers hold and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Pulse that sets the channel enable |
| ch_en | output | 1 | Channel enable, cleared at transaction end |
| req | input | 1 | Granted transfer request pulse |
| cfg_mode | input | 2 | 0 item, 1 block, 2 transaction, 3 as 0 |
| cfg_width | input | 2 | Item width code |
| cfg_blk_bytes | input | BYTE_W | Bytes per block |
| cfg_blk_num | input | BLK_W | Blocks per transaction |
| cmd_valid | output | 1 | Beat command valid |
| cmd_ready | input | 1 | Datapath accepts the beat |
| cmd_bytes | output | 3 | Bytes in this beat (1..4) |
| cmd_blk_last | output | 1 | Beat ends a block |
| cmd_txn_last | output | 1 | Beat ends the transaction |
| flags | output | 3 | Sticky flags: bit0 item, bit1 block, bit2 transaction |
| flag_clr | input | 3 | Write-one-to-clear strobes for flags |
| irq_mask | input | 3 | Per-flag interrupt enable |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench goes after blocks whose size is not a multiple of the width. A sequencer that gets this wrong moves too many bytes or never reaches the block end. It also reprograms size and count in the middle of a transaction; a design without shadowing would shorten the running block. Other corner cases are a flag clear that arrives in the same cycle as a new set, and back-pressure held for several cycles. A wrong design would lose the flag in the first case, and in the second would change the command or post completion early. Zero counts and requests made while the channel is disabled are also driven. A design that gets these wrong would underflow its counters or start a phantom beat.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MODE_ITEM  = 2'd0,
    MODE_BLOCK = 2'd1,
    MODE_TXN   = 2'd2,
    MODE_RSVD  = 2'd3
  } xfer_mode_e;

  localparam int FLAG_ITEM = 0;
  localparam int FLAG_BLK  = 1;
  localparam int FLAG_TXN  = 2;
  localparam int NUM_FLAGS = 3;

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_bytes.sv
module dma_seq_bytes #(
  parameter int BYTE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic [BYTE_W-1:0] reload_val,
  input  logic              beat,
  input  logic [1:0]        width_code,
  output logic [2:0]        beat_bytes,
  output logic              blk_end
);
  import dma_seq_pkg::*;

  localparam int PAD = BYTE_W - 3;

  logic [BYTE_W-1:0] rem_q;
  logic [2:0]        wb;
  logic [BYTE_W-1:0] wb_ext;

  assign wb         = width_bytes(width_code);
  assign wb_ext     = {{PAD{1'b0}}, wb};
  assign blk_end    = (rem_q <= wb_ext);
  assign beat_bytes = blk_end ? rem_q[2:0] : wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
    end else if (beat) begin
      if (blk_end) rem_q <= reload_val;
      else         rem_q <= rem_q - wb_ext;
    end
  end
endmodule

// File: rtl/dma_seq_blocks.sv
module dma_seq_blocks #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             advance,
  output logic             last_blk
);
  localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

  logic [BLK_W-1:0] rem_q;

  assign last_blk = (rem_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= ONE;
    end else if (load) begin
      rem_q <= load_val;
    end else if (advance && !last_blk) begin
      rem_q <= rem_q - ONE;
    end
  end
endmodule

// File: rtl/dma_seq_flags.sv
module dma_seq_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags,
  output logic          irq
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/dma_mode_seq.sv
module dma_mode_seq #(
  parameter int BYTE_W = 24,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_set,
  output logic              ch_en,
  input  logic              req,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_width,
  input  logic [BYTE_W-1:0] cfg_blk_bytes,
  input  logic [BLK_W-1:0]  cfg_blk_num,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_bytes,
  output logic              cmd_blk_last,
  output logic              cmd_txn_last,
  output logic [2:0]        flags,
  input  logic [2:0]        flag_clr,
  input  logic [2:0]        irq_mask,
  output logic              irq
);
  import dma_seq_pkg::*;

  logic              busy_q, open_q, en_q;
  xfer_mode_e        mode_q;
  logic [1:0]        width_q;
  logic [BYTE_W-1:0] sh_size_q;
  logic [BYTE_W-1:0] size_fix;
  logic [BLK_W-1:0]  blks_fix;
  logic              req_acc, start, hs, blk_end, last_blk, txn_end, stop;
  logic [NUM_FLAGS-1:0] flag_set;

  assign size_fix = (cfg_blk_bytes == '0) ? BYTE_W'(1) : cfg_blk_bytes;
  assign blks_fix = (cfg_blk_num == '0) ? BLK_W'(1) : cfg_blk_num;

  assign req_acc = req && en_q && !busy_q;
  assign start   = req_acc && !open_q;
  assign hs      = busy_q && cmd_ready;
  assign txn_end = hs && blk_end && last_blk;

  always_comb begin
    case (mode_q)
      MODE_BLOCK: stop = hs && blk_end;
      MODE_TXN:   stop = txn_end;
      default:    stop = hs;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      open_q    <= 1'b0;
      en_q      <= 1'b0;
      mode_q    <= MODE_ITEM;
      width_q   <= 2'd0;
      sh_size_q <= BYTE_W'(1);
    end else begin
      if (req_acc) begin
        busy_q  <= 1'b1;
        mode_q  <= xfer_mode_e'(cfg_mode);
        width_q <= cfg_width;
      end else if (stop) begin
        busy_q  <= 1'b0;
      end
      if (start)        open_q <= 1'b1;
      else if (txn_end) open_q <= 1'b0;
      if (start) sh_size_q <= size_fix;
      if (en_set)       en_q <= 1'b1;
      else if (txn_end) en_q <= 1'b0;
    end
  end

  dma_seq_bytes #(.BYTE_W(BYTE_W)) u_bytes (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_val   (size_fix),
    .reload_val (sh_size_q),
    .beat       (hs),
    .width_code (width_q),
    .beat_bytes (cmd_bytes),
    .blk_end    (blk_end)
  );

  dma_seq_blocks #(.BLK_W(BLK_W)) u_blocks (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (blks_fix),
    .advance  (hs && blk_end),
    .last_blk (last_blk)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_ITEM] = hs;
    flag_set[FLAG_BLK]  = hs && blk_end;
    flag_set[FLAG_TXN]  = txn_end;
  end

  dma_seq_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .mask  (irq_mask),
    .flags (flags),
    .irq   (irq)
  );

  assign ch_en        = en_q;
  assign cmd_valid    = busy_q;
  assign cmd_blk_last = blk_end;
  assign cmd_txn_last = blk_end && last_blk;
endmodule

// File: rtl/dma_mode_seq_chk.sv
module dma_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_en,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_bytes,
  input logic       cmd_blk_last,
  input logic [2:0] flags,
  input logic [2:0] flag_clr
);
  // R12
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bytes) && $stable(cmd_blk_last));

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !cmd_valid);

  // R2
  beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_bytes != 3'd0) && (cmd_bytes <= 3'd4));

  // R6
  item_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> flags[0]);

  // R7
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_en) |-> flags[2]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] && !flag_clr[1] |=> flags[1]);
endmodule

bind dma_mode_seq dma_mode_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ch_en        (ch_en),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_bytes    (cmd_bytes),
  .cmd_blk_last (cmd_blk_last),
  .flags        (flags),
  .flag_clr     (flag_clr)
);

// File: tb/dma_mode_seq_tb_top.sv
module dma_mode_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_set = 1'b0;
  logic        ch_en;
  logic        req = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_width = 2'd0;
  logic [23:0] cfg_blk_bytes = 24'd1;
  logic [7:0]  cfg_blk_num = 8'd1;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [2:0]  cmd_bytes;
  logic        cmd_blk_last, cmd_txn_last;
  logic [2:0]  flags;
  logic [2:0]  flag_clr = 3'd0;
  logic [2:0]  irq_mask = 3'd0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dma_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .ch_en(ch_en), .req(req),
    .cfg_mode(cfg_mode), .cfg_width(cfg_width), .cfg_blk_bytes(cfg_blk_bytes),
    .cfg_blk_num(cfg_blk_num), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bytes(cmd_bytes), .cmd_blk_last(cmd_blk_last), .cmd_txn_last(cmd_txn_last),
    .flags(flags), .flag_clr(flag_clr), .irq_mask(irq_mask), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // vector: mode[15:14] width[13:12] size[11:4] blocks[3:0]
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 2'd2, 8'd6, 4'd2},
    {2'd1, 2'd1, 8'd5, 4'd3},
    {2'd2, 2'd0, 8'd3, 4'd2},
    {2'd2, 2'd2, 8'd9, 4'd1},
    {2'd1, 2'd2, 8'd4, 4'd2},
    {2'd3, 2'd3, 8'd2, 4'd1}
  };

  function automatic int wbytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic pulse_en();
    @(negedge clk) en_set = 1'b1;
    @(negedge clk) en_set = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  task automatic run_req(output int beats, output int bytes);
    beats = 0;
    bytes = 0;
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    while (cmd_valid && beats < 1000) begin
      if (cmd_ready) begin
        beats++;
        bytes += int'(cmd_bytes);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset en", int'(ch_en), 0);
    check("R1 reset valid", int'(cmd_valid), 0);
    check("R8 reset flags", int'(flags), 0);
    check("R9 reset irq", int'(irq), 0);

    // R1 request while disabled is ignored
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ignored req valid", int'(cmd_valid), 0);
    check("R1 ignored req flags", int'(flags), 0);

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      int w, sz, nb, bpb, reqs, sum, exp_beats;
      cfg_mode      = VEC[v][15:14];
      cfg_width     = VEC[v][13:12];
      cfg_blk_bytes = 24'(VEC[v][11:4]);
      cfg_blk_num   = 8'(VEC[v][3:0]);
      w   = wbytes(VEC[v][13:12]);
      sz  = int'(VEC[v][11:4]);
      nb  = int'(VEC[v][3:0]);
      bpb = (sz + w - 1) / w;
      exp_beats = (cfg_mode == 2'd1) ? bpb : (cfg_mode == 2'd2) ? bpb * nb : 1;
      pulse_en();
      reqs = 0;
      sum = 0;
      while (ch_en && reqs < 100) begin
        run_req(b, n);
        reqs++;
        sum += n;
        check($sformatf("R3 R4 R5 vec%0d beats per req", v), b, exp_beats);
      end
      check($sformatf("R2 vec%0d bytes", v), sum, sz * nb);
      check($sformatf("R5 vec%0d requests", v), reqs, (nb * bpb) / exp_beats);
      check($sformatf("R7 vec%0d txn flag", v), int'(flags[2]), 1);
      clear_flags();
    end

    // R6 flag levels, item mode, size 3 width 2, two blocks
    cfg_mode = 2'd0; cfg_width = 2'd1; cfg_blk_bytes = 24'd3; cfg_blk_num = 8'd2;
    pulse_en();
    run_req(b, n);
    check("R2 first item bytes", n, 2);
    check("R6 mid block flags", int'(flags), 3'b001);
    clear_flags();
    run_req(b, n);
    check("R2 short item bytes", n, 1);
    check("R6 block end flags", int'(flags), 3'b011);
    clear_flags();
    run_req(b, n);
    check("R6 second block flags", int'(flags), 3'b001);
    clear_flags();
    run_req(b, n);
    check("R6 txn end flags", int'(flags), 3'b111);
    check("R7 enable cleared", int'(ch_en), 0);

    // R9 masking
    irq_mask = 3'b000; @(negedge clk);
    check("R9 all masked", int'(irq), 0);
    irq_mask = 3'b010; @(negedge clk);
    check("R9 block unmasked", int'(irq), 1);
    clear_flags();
    check("R9 cleared", int'(irq), 0);
    irq_mask = 3'b000;

    // R8 set beats clear in the same cycle; sticky otherwise
    cfg_mode = 2'd0; cfg_width = 2'd2; cfg_blk_bytes = 24'd8; cfg_blk_num = 8'd1;
    pulse_en();
    @(negedge clk) req = 1'b1;
    @(negedge clk) begin req = 1'b0; flag_clr = 3'b001; end
    @(negedge clk) flag_clr = 3'b000;
    check("R8 set wins", int'(flags[0]), 1);
    repeat (3) @(negedge clk);
    check("R8 sticky", int'(flags[0]), 1);
    clear_flags();
    check("R8 w1c", int'(flags[0]), 0);

    // R12 back-pressure on the open transaction's second item
    cmd_ready = 1'b0;
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 valid held", int'(cmd_valid), 1);
    check("R12 bytes held", int'(cmd_bytes), 4);
    check("R12 no flag", int'(flags), 0);
    cmd_ready = 1'b1;
    @(negedge clk);
    check("R12 done", int'(flags), 3'b111);
    check("R7 en after stall", int'(ch_en), 0);
    clear_flags();

    // R10 shadowed size and count
    cfg_mode = 2'd1; cfg_width = 2'd2; cfg_blk_bytes = 24'd8; cfg_blk_num = 8'd2;
    pulse_en();
    run_req(b, n);
    check("R10 first block", n, 8);
    cfg_blk_bytes = 24'd2; cfg_blk_num = 8'd5;
    run_req(b, n);
    check("R10 old size kept", n, 8);
    check("R10 old count kept", int'(ch_en), 0);
    pulse_en();
    run_req(b, n);
    check("R10 new size", n, 2);
    cfg_mode = 2'd2;
    run_req(b, n);
    check("R10 new count", n, 8);
    check("R10 txn closed", int'(ch_en), 0);
    clear_flags();

    // R11 zero counts behave as one
    cfg_mode = 2'd2; cfg_width = 2'd2; cfg_blk_bytes = 24'd0; cfg_blk_num = 8'd0;
    pulse_en();
    run_req(b, n);
    check("R11 zero beats", b, 1);
    check("R11 zero bytes", n, 1);
    check("R11 zero closes", int'(ch_en), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule